// File: doc/BRIEF.md
# Host Register Access Decoder

This block sits between a host processor and the register set of a serial-bus command controller. The host presents a 4-bit register address on pins, a direction line and a strobe, plus a 16-bit write-data bus. The block merges the pin address with a 4-bit address field held in its own control register to form the effective address. It then either returns the selected register on a 16-bit read bus or, for the control register, captures a write.

Two addressing styles result. In pin addressing, software keeps the control-register address field at zero and the pins alone pick the register. In two-step addressing, software first writes the target address into the control field and then holds the pins low for the following accesses. The control register, including a message-start bit, is exported to the rest of the controller. Status, error, command-word and response-status values arrive as inputs and are only read here. The host interface is a strobe handshake with no back-pressure: a read is answered combinationally, and a write completes on the first clock after the strobe rises.

Top module: `hrd_host_regs`

## Requirements
- R1: Effective address bit n equals host_addr[n] OR control bit 7+n, for n = 0..3 (address field in control bits 10:7, bit 7 the least significant).
- R2: While host_stb=1 and host_rw=1, host_rdata shows the register at the effective address: 0 control, 1 status, 2 error, 3 command word 1, 4 command word 2, 5 response status 1, 6 response status 2; addresses 7..15 read as zero.
- R3: When host_stb=0 or host_rw=0, host_rdata is zero.
- R4: A write (host_rw=0) to effective address 0 loads host_wdata into the control register at the first rising clock at which the strobe is seen high. The strobe is sampled once per clock. Keeping the strobe high does not write again.
- R5: A strobe with host_rw=1, or with an effective address other than 0, leaves the control register unchanged.
- R6: Control bit 1 (message start) is changed only by host writes. start_pulse is high for exactly one cycle, in the cycle the register update is visible, when a write changes bit 1 from 0 to 1. Writing 1 over 1 gives no pulse.
- R7: With rst_n low, the control register and start_pulse are zero.
- R8: Once the address field is nonzero, the effective address cannot be 0, so pin writes to address 0 do not reach the control register. With the pins low, reads return the register named by the field. Reset restores pin addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| host_addr | input | 4 | Register address pins |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_stb | input | 1 | Access strobe, high = active |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| stat_in | input | 16 | Status register value |
| err_in | input | 16 | Error register value |
| cmd1_in | input | 16 | Command word 1 value |
| cmd2_in | input | 16 | Command word 2 value |
| rsp1_in | input | 16 | Response status word 1 value |
| rsp2_in | input | 16 | Response status word 2 value |
| ctrl_out | output | 16 | Control register |
| start_pulse | output | 1 | One-cycle pulse on a 0-to-1 write of the start bit |

## Verification
Random reads with all pin addresses and distinct random register values show whether the mux decodes each address, including the zero-reading upper range. Random writes whose data sometimes carry a nonzero address field show whether the OR merge locks out control writes, and whether later reads follow the field rather than the pins. Directed cases separate a single write from a held strobe, a write to address 0 from a read there, and a 0-to-1 start transition from a 1-over-1 rewrite.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int FIELD_LSB = 7;
  localparam int START_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 4'd0,
    RA_STAT = 4'd1,
    RA_ERR  = 4'd2,
    RA_CMD1 = 4'd3,
    RA_CMD2 = 4'd4,
    RA_RSP1 = 4'd5,
    RA_RSP2 = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/hrd_addr_merge.sv
module hrd_addr_merge #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] pin_addr,
  input  logic [AW-1:0] field_addr,
  output logic [AW-1:0] eff_addr
);
  for (genvar n = 0; n < AW; n++) begin : g_bit
    assign eff_addr[n] = pin_addr[n] | field_addr[n];
  end

  always_comb begin
    for (int k = 0; k < AW; k++)
      if (field_addr[k]) a_r1_field_sets_bit: assert (eff_addr[k]);
  end
endmodule

// File: rtl/hrd_ctrl_reg.sv
module hrd_ctrl_reg #(
  parameter int DW = 16,
  parameter int SBIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          rw,
  input  logic          hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl,
  output logic          start_pulse
);
  logic stb_q;
  logic wr_fire;

  assign wr_fire = stb & ~stb_q & ~rw & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q       <= 1'b0;
      ctrl        <= '0;
      start_pulse <= 1'b0;
    end else begin
      stb_q       <= stb;
      start_pulse <= wr_fire & wdata[SBIT] & ~ctrl[SBIT];
      if (wr_fire) ctrl <= wdata;
    end
  end

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && !stb_q && !rw && hit) |=> $stable(ctrl));
  a_r6_start_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl[SBIT]) |-> $past(stb && !rw));
  a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (ctrl[SBIT] && !$past(ctrl[SBIT])));
  a_r4_single_write_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && stb_q) |=> $stable(ctrl));
endmodule

// File: rtl/hrd_read_mux.sv
module hrd_read_mux
  import hrd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] err,
  input  logic [DW-1:0] cmd1,
  input  logic [DW-1:0] cmd2,
  input  logic [DW-1:0] rsp1,
  input  logic [DW-1:0] rsp2,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    unique case (addr)
      RA_CTRL: sel = ctrl;
      RA_STAT: sel = stat;
      RA_ERR:  sel = err;
      RA_CMD1: sel = cmd1;
      RA_CMD2: sel = cmd2;
      RA_RSP1: sel = rsp1;
      RA_RSP2: sel = rsp2;
      default: sel = '0;
    endcase
  end

  assign rdata = rd_en ? sel : '0;

  always_comb begin
    if (!rd_en) a_r3_idle_zero: assert (rdata == '0);
  end
endmodule

// File: rtl/hrd_host_regs.sv
module hrd_host_regs
  import hrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rw,
  input  logic              host_stb,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] stat_in,
  input  logic [DATA_W-1:0] err_in,
  input  logic [DATA_W-1:0] cmd1_in,
  input  logic [DATA_W-1:0] cmd2_in,
  input  logic [DATA_W-1:0] rsp1_in,
  input  logic [DATA_W-1:0] rsp2_in,
  output logic [DATA_W-1:0] ctrl_out,
  output logic              start_pulse
);
  localparam int FIELD_MSB = FIELD_LSB + ADDR_W - 1;

  logic [ADDR_W-1:0] eff_addr;
  logic              ctrl_hit;

  hrd_addr_merge #(.AW(ADDR_W)) u_merge (
    .pin_addr  (host_addr),
    .field_addr(ctrl_out[FIELD_MSB:FIELD_LSB]),
    .eff_addr  (eff_addr)
  );

  assign ctrl_hit = (eff_addr == RA_CTRL);

  hrd_ctrl_reg #(.DW(DATA_W), .SBIT(START_BIT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (host_stb),
    .rw         (host_rw),
    .hit        (ctrl_hit),
    .wdata      (host_wdata),
    .ctrl       (ctrl_out),
    .start_pulse(start_pulse)
  );

  hrd_read_mux #(.DW(DATA_W), .AW(ADDR_W)) u_mux (
    .rd_en(host_stb & host_rw),
    .addr (eff_addr),
    .ctrl (ctrl_out),
    .stat (stat_in),
    .err  (err_in),
    .cmd1 (cmd1_in),
    .cmd2 (cmd2_in),
    .rsp1 (rsp1_in),
    .rsp2 (rsp2_in),
    .rdata(host_rdata)
  );

  a_r8_field_blocks_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out[FIELD_MSB:FIELD_LSB] != '0) |=> $stable(ctrl_out));
endmodule

// File: tb/hrd_host_regs_test.sv
module hrd_host_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  host_addr = 0;
  logic        host_rw = 1;
  logic        host_stb = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic [15:0] stat_in, err_in, cmd1_in, cmd2_in, rsp1_in, rsp2_in;
  logic [15:0] ctrl_out;
  logic        start_pulse;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_ctrl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hrd_host_regs uut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] eff(input logic [3:0] pins);
    return pins | model_ctrl[10:7];
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return model_ctrl;
      4'd1: return stat_in;
      4'd2: return err_in;
      4'd3: return cmd1_in;
      4'd4: return cmd2_in;
      4'd5: return rsp1_in;
      4'd6: return rsp2_in;
      default: return 16'h0;
    endcase
  endfunction

  task automatic new_regs();
    stat_in = 16'($urandom); err_in = 16'($urandom);
    cmd1_in = 16'($urandom); cmd2_in = 16'($urandom);
    rsp1_in = 16'($urandom); rsp2_in = 16'($urandom);
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    @(negedge clk);
    host_addr = a; host_rw = 1; host_stb = 1;
    #1 check(req, host_rdata, exp_read(eff(a)));
    @(negedge clk);
    host_stb = 0;
    #1 check("R3", host_rdata, 16'h0);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d, input string req);
    logic hit;
    logic exp_pulse;
    @(negedge clk);
    hit = (eff(a) == 4'd0);
    exp_pulse = hit && d[1] && !model_ctrl[1];
    host_addr = a; host_rw = 0; host_wdata = d; host_stb = 1;
    #1 check("R3", host_rdata, 16'h0);
    @(negedge clk);
    if (hit) model_ctrl = d;
    check(req, ctrl_out, model_ctrl);
    check("R6", {15'h0, start_pulse}, {15'h0, exp_pulse});
    host_stb = 0;
    @(negedge clk);
    check("R6", {15'h0, start_pulse}, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1 check("R7", ctrl_out, 16'h0);
    check("R7", {15'h0, start_pulse}, 16'h0);
    model_ctrl = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1553_6110));
    new_regs();
    repeat (3) @(negedge clk);
    check("R7", ctrl_out, 16'h0);
    check("R7", {15'h0, start_pulse}, 16'h0);
    rst_n = 1;

    // R2: every pin address with field zero
    for (int a = 0; a < 16; a++) do_read(4'(a), "R2");

    // R4 / R6: start bit rise, rewrite, clear
    do_write(4'd0, 16'h0002, "R4");
    do_write(4'd0, 16'h0002, "R6");
    do_write(4'd0, 16'h0000, "R6");
    do_write(4'd0, 16'h0003, "R6");

    // R5: writes to other addresses, read strobe at address 0
    do_write(4'd3, 16'hFFFF, "R5");
    do_write(4'd9, 16'h1234, "R5");
    @(negedge clk);
    host_addr = 0; host_rw = 1; host_stb = 1; host_wdata = 16'hBEEF;
    @(negedge clk);
    host_stb = 0;
    check("R5", ctrl_out, model_ctrl);

    // R4: held strobe writes only once
    @(negedge clk);
    host_addr = 0; host_rw = 0; host_wdata = 16'h0004; host_stb = 1;
    @(negedge clk);
    model_ctrl = 16'h0004;
    host_wdata = 16'h0078;
    repeat (3) @(negedge clk);
    check("R4", ctrl_out, 16'h0004);
    host_stb = 0;

    // R8 / R1: two-step addressing with field = 5
    do_write(4'd0, 16'h0280, "R8");
    do_read(4'd0, "R8");
    do_read(4'd2, "R1");
    do_write(4'd0, 16'h0000, "R8");
    check("R8", ctrl_out, 16'h0280);
    do_reset();
    do_read(4'd0, "R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      new_regs();
      d = 16'($urandom);
      if ($urandom_range(3) != 0) d[10:7] = 0;
      if ($urandom_range(1) == 0) do_write(4'($urandom_range(15)), d, "R4");
      else do_read(4'($urandom_range(15)), "R2");
      if ($urandom_range(19) == 0) do_reset();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule